// File: doc/BRIEF.md
# Dual-Mode PWM Timer Channel

A 16-bit timer that drives a single pulse-width-modulated output. A counter runs continuously against a modulus. In edge mode it counts up and wraps. In center mode it counts up to the modulus and then back down to zero. The output is active while the count is below a channel compare value. A polarity bit selects whether "active" means high or low.

Software reaches the block through a byte-wide write port. The modulus and the compare value are each written as two bytes into a staging buffer. A staged value becomes active only after both of its bytes have been written and the counter is at zero. This means a period never runs with a half-updated 16-bit value.

The write port has no back-pressure: every strobe is accepted in the cycle it is presented. There is no streaming data path, so all pins are plain control and status signals. The overflow output is a one-cycle pulse that marks the start of each period.

Top module: `pwm_timer_chan`

## Requirements
- R1: While `rst` is high, `pwm_out` and `ovf_pulse` are 0. Reset clears the counter, both staging buffers, their byte flags, the active modulus M, the active compare value V and the control bits.
- R2: In edge mode (control bit 0 = 0), the counter steps 0, 1, …, M and then returns to 0, so the period is M+1 cycles. `ovf_pulse` is high for exactly one cycle: the cycle in which the counter holds 0 after the wrap.
- R3: In edge mode, the output is active for the counts 0 to V-1 of each period. V = 0 gives 0 % duty. V > M gives 100 % duty. `pwm_out` in a given cycle reflects the count held in the previous cycle.
- R4: In center mode (control bit 0 = 1), the counter steps 0, 1, …, M, M-1, …, 1 and then returns to 0, so the period is 2M cycles. `ovf_pulse` marks the cycle at zero that follows the turn.
- R5: In center mode with bit 15 of V clear:
  - for 0 < V < M, the output is active for 2V cycles per period;
  - for V = M, it is active for 2M-1 cycles;
  - for V > M, it is active for the whole period (100 %).
- R6: In center mode, V = 0 or V with bit 15 set gives 0 % duty.
- R7: Control bit 1 (polarity) inverts the output in both modes. With polarity 1, "active" drives `pwm_out` low.
- R8: Byte writes go only to the staging buffers. A buffer is copied to its active register only when both of its byte flags are set and the counter holds 0. The commit clears both flags. A single byte write therefore never changes the output.
- R9: The write addresses are:
  - 0 and 1: low and high byte of the modulus;
  - 2 and 3: low and high byte of the compare value;
  - 4: control (bit 0 mode, bit 1 polarity).
  Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe, always accepted |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Byte written |
| pwm_out | output | 1 | Registered PWM output |
| ovf_pulse | output | 1 | One-cycle pulse at each period start |

## Verification
The hardest state to reach from the ports is a half-staged update: one byte of a value has been written, and the counter then passes zero one or more times before the partner byte arrives. The bench writes only the low compare byte and runs several full periods to show the duty is unchanged. It then supplies the high byte and checks that the new duty appears only after the next zero. Random runs change mode and modulus while the counter is mid-period. This exercises commits that land at the zero point of a counter still running on its previous settings. A cycle-by-cycle model checks every output sample.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MOD_LO = 3'd0,
    A_MOD_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_CTRL   = 3'd4
  } reg_addr_e;

  localparam int CTRL_CENTER = 0;
  localparam int CTRL_POL    = 1;
endpackage

// File: rtl/pwm_regbuf.sv
module pwm_regbuf #(
  parameter int BYTE_W = 8,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              at_zero,
  output logic [VAL_W-1:0]  act
);
  logic [BYTE_W-1:0] stage_lo, stage_hi;
  logic              got_lo, got_hi;
  logic              commit;

  assign commit = at_zero && got_lo && got_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
      stage_hi <= '0;
      got_lo   <= 1'b0;
      got_hi   <= 1'b0;
      act      <= '0;
    end else begin
      if (commit) begin
        act    <= {stage_hi, stage_lo};
        got_lo <= 1'b0;
        got_hi <= 1'b0;
      end
      if (wr_lo) begin
        stage_lo <= wr_data;
        got_lo   <= 1'b1;
      end
      if (wr_hi) begin
        stage_hi <= wr_data;
        got_hi   <= 1'b1;
      end
    end
  end

  AST_COMMIT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> $past(at_zero)); // R8
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (commit && !wr_lo && !wr_hi) |=> (!got_lo && !got_hi)); // R8
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             center,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_nx;
  logic             up_nx;
  logic             wrap;

  always_comb begin
    cnt_nx = cnt + 1'b1;
    up_nx  = 1'b1;
    wrap   = 1'b0;
    if (!center) begin
      if (cnt >= modv) begin
        cnt_nx = '0;
        wrap   = 1'b1;
      end
    end else if (!(up && cnt < modv)) begin
      if (cnt <= 1) begin
        cnt_nx = '0;
        wrap   = 1'b1;
      end else begin
        cnt_nx = cnt - 1'b1;
        up_nx  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      up    <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      up    <= up_nx;
      ovf_q <= wrap;
    end
  end

  AST_CNT_WITHIN_MOD: assert property (@(posedge clk) disable iff (rst)
    cnt <= modv); // R2
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt == '0 && up)); // R2
  AST_DOWN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    !up |-> (cnt != '0)); // R4
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             center,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic             up,
  input  logic [CNT_W-1:0] cmpv,
  output logic             pwm_q
);
  logic active;

  always_comb begin
    if (center)
      active = !cmpv[CNT_W-1] && (up ? (cnt < cmpv) : (cnt <= cmpv));
    else
      active = cnt < cmpv;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= active ^ pol;
  end

  AST_NEG_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (center && cmpv[CNT_W-1]) |=> (pwm_q == $past(pol))); // R6
  AST_ZERO_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmpv == '0) |=> (pwm_q == $past(pol))); // R3
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              ovf_pulse
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0]       ctrl;
  logic [CNT_W-1:0] mod_act, cmp_act, cnt;
  logic             up, at_zero;
  logic             wr_mlo, wr_mhi, wr_clo, wr_chi;

  assign wr_mlo  = wr_en && (wr_addr == A_MOD_LO);
  assign wr_mhi  = wr_en && (wr_addr == A_MOD_HI);
  assign wr_clo  = wr_en && (wr_addr == A_CMP_LO);
  assign wr_chi  = wr_en && (wr_addr == A_CMP_HI);
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl <= wr_data[1:0];
  end

  pwm_regbuf #(.BYTE_W(BYTE_W)) u_mod (
    .clk(clk), .rst(rst), .wr_lo(wr_mlo), .wr_hi(wr_mhi),
    .wr_data(wr_data), .at_zero(at_zero), .act(mod_act)
  );

  pwm_regbuf #(.BYTE_W(BYTE_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_lo(wr_clo), .wr_hi(wr_chi),
    .wr_data(wr_data), .at_zero(at_zero), .act(cmp_act)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .center(ctrl[CTRL_CENTER]), .modv(mod_act),
    .cnt(cnt), .up(up), .ovf_q(ovf_pulse)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmpo (
    .clk(clk), .rst(rst), .center(ctrl[CTRL_CENTER]), .pol(ctrl[CTRL_POL]),
    .cnt(cnt), .up(up), .cmpv(cmp_act), .pwm_q(pwm_out)
  );

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CTRL) |=> $stable(ctrl)); // R9
endmodule

// File: tb/pwm_timer_chan_test.sv
module pwm_timer_chan_test;
  localparam int CLK_P  = 10;
  localparam int WD_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, ovf_pulse;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] m_cnt, m_mod, m_val, m_mbuf, m_vbuf;
  logic        m_up, m_ml, m_mh, m_vl, m_vh, m_pwm, m_ovf;
  logic [1:0]  m_ctrl;

  pwm_timer_chan uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic act, cm, cv, wr;
    logic [15:0] ncnt;
    logic nup;
    if (rst) begin
      m_cnt = 0; m_up = 1; m_mod = 0; m_val = 0; m_mbuf = 0; m_vbuf = 0;
      {m_ml, m_mh, m_vl, m_vh} = 4'b0; m_ctrl = 0; m_pwm = 0; m_ovf = 0;
      return;
    end
    if (m_ctrl[0]) act = !m_val[15] && (m_up ? (m_cnt < m_val) : (m_cnt <= m_val));
    else           act = m_cnt < m_val;
    m_pwm = act ^ m_ctrl[1];
    ncnt = m_cnt + 1; nup = 1; m_ovf = 0;
    if (!m_ctrl[0]) begin
      if (m_cnt >= m_mod) begin ncnt = 0; m_ovf = 1; end
    end else if (!(m_up && m_cnt < m_mod)) begin
      if (m_cnt <= 1) begin ncnt = 0; m_ovf = 1; end
      else begin ncnt = m_cnt - 1; nup = 0; end
    end
    cm = (m_cnt == 0) && m_ml && m_mh;
    cv = (m_cnt == 0) && m_vl && m_vh;
    if (cm) begin m_mod = m_mbuf; m_ml = 0; m_mh = 0; end
    if (cv) begin m_val = m_vbuf; m_vl = 0; m_vh = 0; end
    m_cnt = ncnt; m_up = nup;
    wr = wr_en;
    if (wr) case (wr_addr)
      3'd0: begin m_mbuf[7:0]  = wr_data; m_ml = 1; end
      3'd1: begin m_mbuf[15:8] = wr_data; m_mh = 1; end
      3'd2: begin m_vbuf[7:0]  = wr_data; m_vl = 1; end
      3'd3: begin m_vbuf[15:8] = wr_data; m_vh = 1; end
      3'd4: m_ctrl = wr_data[1:0];
      default: ;
    endcase
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    if (!rst) begin
      check(m_ctrl[0] ? "R5 pwm per-cycle" : "R3 pwm per-cycle", pwm_out, m_pwm);
      check(m_ctrl[0] ? "R4 ovf per-cycle" : "R2 ovf per-cycle", ovf_pulse, m_ovf);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic setup(input logic [1:0] c, input logic [15:0] md, input logic [15:0] v);
    wr(3'd4, {6'b0, c});
    wr(3'd0, md[7:0]); wr(3'd1, md[15:8]);
    wr(3'd2, v[7:0]);  wr(3'd3, v[15:8]);
  endtask

  function automatic int period_of(input bit cen, input int md);
    return cen ? 2 * md : md + 1;
  endfunction

  function automatic int exp_high(input bit cen, input bit pol, input int md, input logic [15:0] v);
    int p, h;
    p = period_of(cen, md);
    if (cen) begin
      if (v[15] || v == 0) h = 0;
      else if (v > md)     h = p;
      else if (v == md)    h = 2 * md - 1;
      else                 h = 2 * v;
    end else begin
      h = (v > md) ? p : v;
    end
    return pol ? p - h : h;
  endfunction

  task automatic measure(input string tag, input bit cen, input bit pol,
                         input int md, input logic [15:0] v, input int nper);
    int hi = 0, ov = 0;
    for (int i = 0; i < nper * period_of(cen, md); i++) begin
      step();
      hi += pwm_out;
      ov += ovf_pulse;
    end
    check({tag, " high cycles"}, hi, nper * exp_high(cen, pol, md, v));
    check(cen ? "R4 overflow count" : "R2 overflow count", ov, nper);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYC, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1357);
    run(3);
    check("R1 reset pwm", pwm_out, 0);
    check("R1 reset ovf", ovf_pulse, 0);
    rst = 0;
    run(4);

    // edge mode, directed duty and corner cases
    setup(2'b00, 16'd9, 16'd4);  run(40); measure("R3 edge 4/10", 0, 0, 9, 16'd4, 3);
    setup(2'b00, 16'd9, 16'd0);  run(40); measure("R3 edge 0 pct", 0, 0, 9, 16'd0, 2);
    setup(2'b00, 16'd9, 16'd10); run(40); measure("R3 edge 100 pct", 0, 0, 9, 16'd10, 2);
    setup(2'b10, 16'd9, 16'd3);  run(40); measure("R7 edge inverted", 0, 1, 9, 16'd3, 2);

    // center mode directed
    setup(2'b01, 16'd8, 16'd3);    run(60); measure("R5 center 6/16", 1, 0, 8, 16'd3, 3);
    setup(2'b01, 16'd8, 16'd9);    run(60); measure("R5 center 100 pct", 1, 0, 8, 16'd9, 2);
    setup(2'b01, 16'd8, 16'h8004); run(60); measure("R6 center negative", 1, 0, 8, 16'h8004, 2);
    setup(2'b01, 16'd8, 16'd0);    run(60); measure("R6 center zero", 1, 0, 8, 16'd0, 2);
    setup(2'b11, 16'd1, 16'd1);    run(60); measure("R7 center inverted", 1, 1, 1, 16'd1, 4);

    // half-staged update stays inert, then commits at zero
    setup(2'b00, 16'd19, 16'd5); run(60);
    wr(3'd2, 8'd12);
    run(50); measure("R8 single byte inert", 0, 0, 19, 16'd5, 2);
    wr(3'd3, 8'd0);
    run(25); measure("R8 pair commits", 0, 0, 19, 16'd12, 2);

    // unused addresses
    wr(3'd5, 8'hFF); wr(3'd6, 8'h03); wr(3'd7, 8'hAA);
    run(25); measure("R9 unused addresses", 0, 0, 19, 16'd12, 2);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      bit cen, pol;
      int md, kind;
      logic [15:0] v;
      cen = $urandom_range(0, 1);
      pol = $urandom_range(0, 1);
      md = cen ? $urandom_range(1, 40) : $urandom_range(1, 60);
      kind = $urandom_range(0, 4);
      case (kind)
        0: v = 0;
        1: v = 16'(md + $urandom_range(1, 5));
        2: v = cen ? {1'b1, 15'($urandom)} : 16'($urandom_range(0, md));
        default: v = 16'($urandom_range(1, md));
      endcase
      setup({pol, cen}, 16'(md), v);
      run(260);
      measure(cen ? ((v[15] || v == 0) ? "R6 random" : "R5 random") : "R3 random",
              cen, pol, md, v, 3);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule